// File: doc/BRIEF.md
# Two-Wire Slave with 16-bit Register Pairs

This block is the host-facing serial port of a battery gauge. It follows an I2C bus as a slave at a fixed 7-bit address. A host reaches a small map of 16-bit registers through it, one byte at a time. A memory-address byte loads a byte pointer. Each data byte then moves the pointer forward by one. Words are big-endian: the high byte sits at the even address and goes first on the wire.

SCL and SDA are brought into the system clock domain, and all bus work runs on those synchronized samples. The block drives SDA only as an open-drain enable. Cell voltage, charge level and version come in as live words from the gauge core. The compensation word is held inside the block and presented to the core.

Two write codes act as commands. One code, written to the mode word, raises a quick-start strobe. Another, written to the command word, restarts the whole gauge: the block pulses a reset and drops the acknowledge of that final byte.

Top module: `i2c_reg16_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 0110110b: 6Ch selects a write and 6Dh a read. Any other address gets no acknowledge. The block changes its SDA drive only while SCL is low, and in a receive byte it drives SDA only in the acknowledge slot.
- R2: A write of the form [6Ch, pointer, data...] stores data bytes at the pointer and moves the pointer up by one after each byte. The compensation word (pointer 0Ch high byte, 0Dh low byte) takes the written value and reads back the same.
- R3: A word changes only when its even byte and then its odd byte arrive in the same transfer. A single byte, or an odd byte alone, leaves the word unchanged.
- R4: A read first sets the pointer in a write, then sends a repeated START and 6Dh. The pointer survives the repeated START. Bytes come out MSB first, high byte before low byte. Reading from 02h returns the cell-voltage word, and the pointer then runs on into the charge word at 04h.
- R5: The low byte returned in a read comes from the same word sample that supplied its high byte, even if the live input changes between the two bytes.
- R6: Writes are dropped when they target read-only words (02h, 04h, 08h) or reserved pointers. They are also dropped when the pointer reached a word above 4Fh by increment rather than by direct setting. Dropped bytes are still acknowledged.
- R7: Once the pointer passes FFh, reads return FFh. Write-only and reserved words read as 0000h.
- R8: Writing 4000h to the mode word (06h/07h) raises a quick-start strobe for exactly one clock. Any other value raises none.
- R9: Writing 5400h to the command word (FEh/FFh) pulses the soft-reset output once, as soon as the last data bit is sampled. That byte gets no acknowledge, and the compensation word returns to 9700h.
- R10: After reset the compensation word is 9700h, SDA is released and neither strobe is active.
- R11: When the master answers a read byte with a no-acknowledge, the block releases SDA and drives nothing more until the next START.
- R12: A STOP or START inside a byte or between the two bytes of a word aborts the pending write, and the word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| vcell_i | input | 16 | Live cell-voltage word |
| soc_i | input | 16 | Live state-of-charge word |
| version_i | input | 16 | Version word |
| comp_o | output | 16 | Compensation word held by the block |
| quick_start_o | output | 1 | One-clock quick-start strobe |
| soft_reset_o | output | 1 | One-clock full-reset strobe |

## Verification
An SCL edge at the pad reaches the protocol logic after two synchronizer flops and one edge flop. The SDA drive for an acknowledge or a data bit is therefore valid three clocks after SCL falls. The bench holds each SCL phase for eight clocks and samples SDA halfway through the high phase, well after that point. A word commit is registered one clock after the last bit is sampled, and the compensation word and the quick-start strobe follow one clock later. The strobes are counted by a monitor, and the compensation word is checked only after the closing STOP, so no check depends on the exact commit cycle.

// File: rtl/i2c_reg16_pkg.sv
`timescale 1ns/1ps
package i2c_reg16_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned WIDX_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_MADDR, ST_WDATA, ST_TX, ST_WAIT
  } bus_st_e;

  // word index = byte pointer >> 1
  localparam logic [WIDX_W-1:0] WIDX_VCELL = 7'h01;
  localparam logic [WIDX_W-1:0] WIDX_SOC   = 7'h02;
  localparam logic [WIDX_W-1:0] WIDX_MODE  = 7'h03;
  localparam logic [WIDX_W-1:0] WIDX_VER   = 7'h04;
  localparam logic [WIDX_W-1:0] WIDX_COMP  = 7'h06;
  localparam logic [WIDX_W-1:0] WIDX_CMD   = 7'h7F;
endpackage

// File: rtl/i2c_reg16_sync.sv
`timescale 1ns/1ps
module i2c_reg16_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2c_reg16_regs.sv
`timescale 1ns/1ps
module i2c_reg16_regs
  import i2c_reg16_pkg::*;
#(
  parameter logic [WORD_W-1:0] COMP_RST = 16'h9700,
  parameter logic [WORD_W-1:0] QS_CODE  = 16'h4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WIDX_W-1:0] wr_widx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              soft_rst_i,
  input  logic [WIDX_W-1:0] rd_widx_i,
  output logic [WORD_W-1:0] rd_word_o,
  input  logic [WORD_W-1:0] vcell_i,
  input  logic [WORD_W-1:0] soc_i,
  input  logic [WORD_W-1:0] version_i,
  output logic [WORD_W-1:0] comp_o,
  output logic              quick_start_o
);
  logic [WORD_W-1:0] comp_q;
  logic              qs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comp_q <= COMP_RST;
      qs_q   <= 1'b0;
    end else begin
      qs_q <= wr_en_i && (wr_widx_i == WIDX_MODE) && (wr_data_i == QS_CODE);
      if (soft_rst_i)                              comp_q <= COMP_RST;
      else if (wr_en_i && wr_widx_i == WIDX_COMP)  comp_q <= wr_data_i;
    end
  end

  always_comb begin
    unique case (rd_widx_i)
      WIDX_VCELL: rd_word_o = vcell_i;
      WIDX_SOC:   rd_word_o = soc_i;
      WIDX_VER:   rd_word_o = version_i;
      WIDX_COMP:  rd_word_o = comp_q;
      default:    rd_word_o = '0;
    endcase
  end

  assign comp_o        = comp_q;
  assign quick_start_o = qs_q;

  // R8
  qs_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qs_q |=> !qs_q);

  // R9
  soft_restores_comp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (comp_q == COMP_RST));

  // R3
  comp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !soft_rst_i) |=> $stable(comp_q));
endmodule

// File: rtl/i2c_reg16_fsm.sv
`timescale 1ns/1ps
module i2c_reg16_fsm
  import i2c_reg16_pkg::*;
#(
  parameter logic [6:0]        SLV_ADDR = 7'h36,
  parameter logic [BYTE_W-1:0] WR_LIMIT = 8'h4F,
  parameter logic [WORD_W-1:0] RST_CODE = 16'h5400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_hi_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic [WIDX_W-1:0] rd_widx_o,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              wr_en_o,
  output logic [WIDX_W-1:0] wr_widx_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              soft_rst_o,
  output logic              sda_oe_o
);
  localparam logic [3:0] CNT_ACK  = 4'd8;
  localparam logic [3:0] CNT_DONE = 4'd9;

  bus_st_e           state_q, nxt_q;
  logic [3:0]        cnt_q;
  logic [6:0]        sh_q, tx_sh_q;
  logic [BYTE_W-1:0] ptr_q, hold_hi_q, snap_lo_q;
  logic [WIDX_W-1:0] base_w_q, hold_w_q, snap_w_q, wr_widx_q;
  logic [WORD_W-1:0] wr_data_q;
  logic past_end_q, hold_ok_q, snap_ok_q, ack_ok_q, nack_q;
  logic oe_q, wr_en_q, soft_q;

  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic              wr_blocked, go_tx, rx_state;

  assign rx_byte    = {sh_q, sda_i};
  assign rx_state   = (state_q == ST_ADDR) || (state_q == ST_MADDR) || (state_q == ST_WDATA);
  assign wr_blocked = past_end_q || ((ptr_q > WR_LIMIT) && (ptr_q[7:1] != base_w_q));
  assign go_tx      = ((state_q == ST_TX) && !nack_q) || ((state_q == ST_ADDR) && (nxt_q == ST_TX));
  assign rd_widx_o  = ptr_q[7:1];

  always_comb begin
    if (past_end_q)                                    tx_byte = 8'hFF;
    else if (!ptr_q[0])                                tx_byte = rd_word_i[15:8];
    else if (snap_ok_q && snap_w_q == ptr_q[7:1])      tx_byte = snap_lo_q;
    else                                               tx_byte = rd_word_i[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  nxt_q <= ST_IDLE;
      cnt_q <= '0;  sh_q <= '0;  tx_sh_q <= '0;
      ptr_q <= '0;  hold_hi_q <= '0;  snap_lo_q <= '0;
      base_w_q <= '0;  hold_w_q <= '0;  snap_w_q <= '0;
      wr_widx_q <= '0;  wr_data_q <= '0;
      past_end_q <= 1'b0;  hold_ok_q <= 1'b0;  snap_ok_q <= 1'b0;
      ack_ok_q <= 1'b0;  nack_q <= 1'b0;
      oe_q <= 1'b0;  wr_en_q <= 1'b0;  soft_q <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      soft_q  <= 1'b0;
      if (stop_i || start_i) begin
        state_q   <= stop_i ? ST_IDLE : ST_ADDR;
        oe_q      <= 1'b0;
        cnt_q     <= '0;
        hold_ok_q <= 1'b0;
        snap_ok_q <= 1'b0;
      end else if (state_q == ST_IDLE || state_q == ST_WAIT) begin
        cnt_q <= '0;
      end else if (scl_rise_i) begin
        if (cnt_q < CNT_ACK) begin
          cnt_q <= cnt_q + 4'd1;
          if (rx_state) sh_q <= rx_byte[6:0];
          if (cnt_q == 4'd7 && rx_state) begin
            ack_ok_q <= 1'b1;
            unique case (state_q)
              ST_ADDR: begin
                if (rx_byte[7:1] == SLV_ADDR) nxt_q <= rx_byte[0] ? ST_TX : ST_MADDR;
                else begin
                  ack_ok_q <= 1'b0;
                  nxt_q    <= ST_WAIT;
                end
              end
              ST_MADDR: begin
                ptr_q      <= rx_byte;
                base_w_q   <= rx_byte[7:1];
                past_end_q <= 1'b0;
                hold_ok_q  <= 1'b0;
                nxt_q      <= ST_WDATA;
              end
              default: begin
                nxt_q <= ST_WDATA;
                ptr_q <= ptr_q + 8'd1;
                if (ptr_q == 8'hFF) past_end_q <= 1'b1;
                if (!ptr_q[0]) begin
                  hold_hi_q <= rx_byte;
                  hold_w_q  <= ptr_q[7:1];
                  hold_ok_q <= !wr_blocked;
                end else begin
                  hold_ok_q <= 1'b0;
                  if (hold_ok_q && hold_w_q == ptr_q[7:1] && !wr_blocked) begin
                    if (ptr_q[7:1] == WIDX_CMD && {hold_hi_q, rx_byte} == RST_CODE) begin
                      // full restart: no ACK for this byte
                      soft_q     <= 1'b1;
                      state_q    <= ST_IDLE;
                      ack_ok_q   <= 1'b0;
                      ptr_q      <= '0;
                      past_end_q <= 1'b0;
                    end else begin
                      wr_en_q   <= 1'b1;
                      wr_widx_q <= ptr_q[7:1];
                      wr_data_q <= {hold_hi_q, rx_byte};
                    end
                  end
                end
              end
            endcase
          end
        end else if (cnt_q == CNT_ACK) begin
          cnt_q <= CNT_DONE;
          if (state_q == ST_TX) begin
            nack_q <= sda_i;
            if (!sda_i) begin
              ptr_q <= ptr_q + 8'd1;
              if (ptr_q == 8'hFF) past_end_q <= 1'b1;
            end
          end
        end
      end else if (scl_fall_i) begin
        if (cnt_q == CNT_ACK) begin
          oe_q <= rx_state && ack_ok_q;
        end else if (cnt_q == CNT_DONE) begin
          cnt_q <= '0;
          oe_q  <= 1'b0;
          if (go_tx) begin
            state_q <= ST_TX;
            nack_q  <= 1'b0;
            tx_sh_q <= tx_byte[6:0];
            oe_q    <= ~tx_byte[7];
            if (!ptr_q[0]) begin
              snap_lo_q <= rd_word_i[7:0];
              snap_w_q  <= ptr_q[7:1];
              snap_ok_q <= 1'b1;
            end
          end else if (state_q == ST_TX) begin
            state_q <= ST_WAIT;
          end else begin
            state_q <= nxt_q;
          end
        end else if (state_q == ST_TX && cnt_q != 4'd0) begin
          tx_sh_q <= {tx_sh_q[5:0], 1'b0};
          oe_q    <= ~tx_sh_q[6];
        end
      end
    end
  end

  assign wr_en_o    = wr_en_q;
  assign wr_widx_o  = wr_widx_q;
  assign wr_data_o  = wr_data_q;
  assign soft_rst_o = soft_q;
  assign sda_oe_o   = oe_q;

  // R1
  oe_moves_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q != $past(oe_q)) |-> !scl_hi_i);

  // R1
  rx_drive_ack_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && state_q != ST_TX) |-> (cnt_q >= CNT_ACK));

  // R11
  master_ack_slot_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX && cnt_q == CNT_DONE) |-> !oe_q);

  // R11
  wait_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !oe_q);
endmodule

// File: rtl/i2c_reg16_slave.sv
`timescale 1ns/1ps
module i2c_reg16_slave
  import i2c_reg16_pkg::*;
#(
  parameter logic [6:0]        SLV_ADDR = 7'h36,
  parameter logic [BYTE_W-1:0] WR_LIMIT = 8'h4F,
  parameter logic [WORD_W-1:0] COMP_RST = 16'h9700,
  parameter logic [WORD_W-1:0] QS_CODE  = 16'h4000,
  parameter logic [WORD_W-1:0] RST_CODE = 16'h5400,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [15:0] vcell_i,
  input  logic [15:0] soc_i,
  input  logic [15:0] version_i,
  output logic [15:0] comp_o,
  output logic        quick_start_o,
  output logic        soft_reset_o
);
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start_ev, stop_ev;
  logic              wr_en, soft_rst;
  logic [WIDX_W-1:0] wr_widx, rd_widx;
  logic [WORD_W-1:0] wr_data, rd_word;

  i2c_reg16_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_reg16_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  assign start_ev = sda_fall & scl_lvl;
  assign stop_ev  = sda_rise & scl_lvl;

  i2c_reg16_fsm #(
    .SLV_ADDR(SLV_ADDR), .WR_LIMIT(WR_LIMIT), .RST_CODE(RST_CODE)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .scl_hi_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_i(sda_lvl), .start_i(start_ev), .stop_i(stop_ev),
    .rd_widx_o(rd_widx), .rd_word_i(rd_word),
    .wr_en_o(wr_en), .wr_widx_o(wr_widx), .wr_data_o(wr_data),
    .soft_rst_o(soft_rst), .sda_oe_o(sda_oe_o)
  );

  i2c_reg16_regs #(.COMP_RST(COMP_RST), .QS_CODE(QS_CODE)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_widx_i(wr_widx), .wr_data_i(wr_data),
    .soft_rst_i(soft_rst), .rd_widx_i(rd_widx), .rd_word_o(rd_word),
    .vcell_i(vcell_i), .soc_i(soc_i), .version_i(version_i),
    .comp_o(comp_o), .quick_start_o(quick_start_o)
  );

  assign soft_reset_o = soft_rst;
endmodule

// File: tb/i2c_reg16_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_reg16_slave_tb_top;
  localparam int H = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, qs, sr;
  logic [15:0] vcell = 16'hC4A0, soc = 16'h5A3C, ver = 16'h0012, comp;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  int n_run = 0, n_fail = 0, qs_cnt = 0, sr_cnt = 0;
  logic done = 1'b0;

  i2c_reg16_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .vcell_i(vcell), .soc_i(soc), .version_i(ver),
    .comp_o(comp), .quick_start_o(qs), .soft_reset_o(sr)
  );

  always @(posedge clk) begin
    if (qs) qs_cnt <= qs_cnt + 1;
    if (sr) sr_cnt <= sr_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hp;
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; hp; scl_m = 1'b1; hp; sda_m = 1'b0; hp; scl_m = 1'b0; hp;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; hp; scl_m = 1'b1; hp; sda_m = 1'b1; hp;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp; scl_m = 1'b1; hp; scl_m = 1'b0;
    end
    sda_m = 1'b1; hp; scl_m = 1'b1;
    repeat (H/2) @(negedge clk);
    acked = !sda_bus;
    repeat (H/2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hp; scl_m = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_bus;
      repeat (H/2) @(negedge clk);
      scl_m = 1'b0;
    end
    sda_m = mack ? 1'b0 : 1'b1; hp; scl_m = 1'b1; hp; scl_m = 1'b0;
    sda_m = 1'b1;
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [15:0] w, output logic [3:0] acks);
    bus_start;
    send_byte(8'h6C, acks[3]); send_byte(a, acks[2]);
    send_byte(w[15:8], acks[1]); send_byte(w[7:0], acks[0]);
    bus_stop;
  endtask

  task automatic rd_word(input logic [7:0] a, output logic [15:0] w);
    logic k;
    bus_start; send_byte(8'h6C, k); send_byte(a, k);
    bus_start; send_byte(8'h6D, k);
    recv_byte(1'b1, w[15:8]); recv_byte(1'b0, w[7:0]);
    bus_stop;
  endtask

  initial begin
    logic ak, ak2;
    logic [3:0]  acks;
    logic [15:0] w, v;
    logic [7:0]  b0, b1, b2, b3;
    int lows;

    repeat (5) @(negedge clk);
    chk("R10 comp after reset", comp, 16'h9700);
    chk("R10 sda released", sda_oe, 1'b0);
    chk("R10 strobes idle", {qs, sr}, 2'b00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: sweep every 7-bit address
    for (int a = 0; a < 128; a++) begin
      bus_start; send_byte({a[6:0], 1'b0}, ak); bus_stop;
      chk($sformatf("R1 address %0h ack", a), ak, (a == 8'h36));
    end

    // R4: read across cell-voltage and charge words, repeated START keeps pointer
    bus_start; send_byte(8'h6C, ak); send_byte(8'h02, ak);
    bus_start; send_byte(8'h6D, ak);
    chk("R1 read address ack", ak, 1'b1);
    recv_byte(1'b1, b0); recv_byte(1'b1, b1); recv_byte(1'b1, b2); recv_byte(1'b0, b3);
    bus_stop;
    chk("R4 read 02h..05h", {b0, b1, b2, b3}, {vcell, soc});
    rd_word(8'h08, w);
    chk("R4 version word", w, ver);

    // R2: compensation write/readback sweep
    for (int k = 0; k < 16; k++) begin
      v = 16'(k * 16'h1357) ^ 16'hA5C3;
      wr_word(8'h0C, v, acks);
      chk("R2 write acks", acks, 4'hF);
      chk("R2 comp output", comp, v);
      rd_word(8'h0C, w);
      chk("R2 comp readback", w, v);
    end

    // R3: single bytes do not commit
    v = comp;
    bus_start; send_byte(8'h6C, ak); send_byte(8'h0C, ak); send_byte(8'h12, ak); bus_stop;
    chk("R3 lone high byte", comp, v);
    bus_start; send_byte(8'h6C, ak); send_byte(8'h0D, ak); send_byte(8'h34, ak); bus_stop;
    chk("R3 lone low byte", comp, v);

    // R12: abort by repeated START between bytes, and by STOP mid-byte
    bus_start; send_byte(8'h6C, ak); send_byte(8'h0C, ak); send_byte(8'hAB, ak);
    bus_start; send_byte(8'h6C, ak); send_byte(8'h0D, ak); send_byte(8'hCD, ak); bus_stop;
    chk("R12 START between bytes", comp, v);
    bus_start; send_byte(8'h6C, ak); send_byte(8'h0C, ak); send_byte(8'h77, ak);
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; hp; scl_m = 1'b1; hp; scl_m = 1'b0;
    end
    bus_stop;
    chk("R12 STOP mid-byte", comp, v);

    // R5: snapshot of low byte
    bus_start; send_byte(8'h6C, ak); send_byte(8'h02, ak);
    bus_start; send_byte(8'h6D, ak);
    recv_byte(1'b1, b0);
    vcell = 16'h9966;
    recv_byte(1'b0, b1);
    bus_stop;
    chk("R5 snapshot pair", {b0, b1}, 16'hC4A0);
    rd_word(8'h02, w);
    chk("R5 fresh sample", w, 16'h9966);

    // R6: read-only and increment-past-limit writes dropped
    wr_word(8'h04, 16'h0000, acks);
    chk("R6 read-only write acked", acks, 4'hF);
    rd_word(8'h04, w);
    chk("R6 charge word untouched", w, soc);
    bus_start; send_byte(8'h6C, ak); send_byte(8'hFC, ak);
    send_byte(8'h00, ak); send_byte(8'h00, ak); send_byte(8'h54, ak); send_byte(8'h00, ak2);
    bus_stop;
    chk("R6 incremented command dropped", {ak, ak2, 8'(sr_cnt)}, {2'b11, 8'd0});
    chk("R6 comp kept", comp, v);
    bus_start; send_byte(8'h6C, ak); send_byte(8'h0A, ak);
    send_byte(8'h11, ak); send_byte(8'h22, ak); send_byte(8'h1B, ak); send_byte(8'hAD, ak);
    bus_stop;
    chk("R2 auto-increment into comp", comp, 16'h1BAD);

    // R7: past end and write-only reads
    bus_start; send_byte(8'h6C, ak); send_byte(8'hFE, ak);
    bus_start; send_byte(8'h6D, ak);
    recv_byte(1'b1, b0); recv_byte(1'b1, b1); recv_byte(1'b1, b2); recv_byte(1'b0, b3);
    bus_stop;
    chk("R7 FEh..past end", {b0, b1, b2, b3}, 32'h0000FFFF);
    rd_word(8'h06, w);
    chk("R7 mode reads zero", w, 16'h0000);

    // R11: after master NACK the block stays silent
    bus_start; send_byte(8'h6C, ak); send_byte(8'h02, ak);
    bus_start; send_byte(8'h6D, ak);
    recv_byte(1'b0, b0);
    lows = 0;
    for (int i = 0; i < 9; i++) begin
      hp; scl_m = 1'b1;
      if (!sda_bus) lows++;
      hp; if (!sda_bus) lows++;
      scl_m = 1'b0;
    end
    bus_stop;
    chk("R11 no drive after NACK", lows, 0);

    // R8: quick-start only on the exact code
    wr_word(8'h06, 16'h4000, acks);
    chk("R8 quick-start strobe", qs_cnt, 1);
    wr_word(8'h06, 16'h4001, acks);
    wr_word(8'h06, 16'h0040, acks);
    chk("R8 other values ignored", qs_cnt, 1);
    chk("R8 comp untouched", comp, 16'h1BAD);

    // R9: soft reset
    bus_start; send_byte(8'h6C, ak); send_byte(8'hFE, ak);
    send_byte(8'h54, ak); send_byte(8'h00, ak2);
    bus_stop;
    chk("R9 acks high/low", {ak, ak2}, 2'b10);
    chk("R9 reset pulses", sr_cnt, 1);
    chk("R9 comp restored", comp, 16'h9700);
    rd_word(8'h0C, w);
    chk("R9 comp readback", w, 16'h9700);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule